// File: doc/BRIEF.md
# Prioritised Event Interrupt Controller

This block gathers eight numbered event sources into one pending set and raises a single fast-interrupt request toward a processor while any event is outstanding. An event is signalled by a one-cycle valid strobe together with a 3-bit event index. Alongside the request line, the block holds an event-number register that tells the processor which event to service next.

The processor acknowledges by pulsing a clear-register write strobe. Only every fourth such write retires anything. A retiring write removes the lowest-numbered pending event and loads the event-number register with the next pending index, when there is one. The event-number register follows a plain priority rule on arrival: a new event replaces the stored number only when the stored number is zero or larger than the new index. Because of this rule, event 0 can be displaced by a later, larger event.

Top module: `evt_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the pending mask, the acknowledge count, the event-number register and the interrupt line all become 0.
- R2: An event strobe with index k sets bit k of `pend_mask_o` (bit k stands for event k) at the next clock edge, and no other bit changes because of that strobe.
- R3: `irq_o` is high exactly when `pend_mask_o` is non-zero. It rises on the edge that takes the mask out of the empty state and falls on the edge that empties it.
- R4: An arriving event with index k loads k into `evt_num_o` when the register holds 0 or holds a value greater than k. Otherwise the register keeps its value.
- R5: The first, second and third clear writes after reset or after a retiring write leave the pending mask and `evt_num_o` unchanged.
- R6: The fourth clear write resets the acknowledge count to 0 and clears the lowest set bit of the pending mask.
- R7: After a retiring write clears bit i, `evt_num_o` takes the lowest remaining pending index at or above i. If no bit remains set, `evt_num_o` keeps its value.
- R8: When an event strobe and a retiring clear write occur in the same cycle, the clear is applied first and the new event is then added. The new event's bit is set afterwards, and its index is compared against the post-retire register value.
- R9: A retiring clear write with an empty pending mask changes neither the mask nor `evt_num_o`, but it still restarts the count of four.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid_i | input | 1 | One-cycle strobe: an event is raised this cycle |
| evt_idx_i | input | 3 | Index (0 to 7) of the raised event |
| ack_wr_i | input | 1 | One-cycle strobe: a write to the clear register |
| irq_o | output | 1 | Fast-interrupt request, high while any event is pending |
| evt_num_o | output | 3 | Event number the processor should service |
| pend_mask_o | output | 8 | Pending mask, bit k for event k |

## Verification
An event arrival and a retiring (fourth) clear write can occur in the same clock cycle. In that case the pending mask and the event-number register each receive two updates that must be applied in a fixed order. The bench provokes this by counting three clear writes and then driving the fourth write together with an event strobe whose index is lower than the register value that the retire produces. The scoreboard model applies the clear before the event, so a passing result shows that the new bit survives and that the register ends on the new, smaller index and not on the retire's choice.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;

    localparam int EVT_COUNT = 8;
    localparam int EVT_IDX_W = $clog2(EVT_COUNT);

    typedef logic [EVT_COUNT-1:0] evt_mask_t;
    typedef logic [EVT_IDX_W-1:0] evt_idx_t;

    // An incoming event request
    typedef struct packed {
        logic     valid;
        evt_idx_t idx;
    } evt_req_t;

    // Result of a priority search over the mask
    typedef struct packed {
        logic     hit;
        evt_idx_t idx;
    } evt_pick_t;

    // Lowest set bit of m whose position is at or above start
    function automatic evt_pick_t pick_lowest_from(evt_mask_t m, evt_idx_t start);
        evt_pick_t r;
        r = '0;
        for (int i = EVT_COUNT - 1; i >= 0; i--) begin
            if (m[i] && (i >= int'(start))) begin
                r.hit = 1'b1;
                r.idx = evt_idx_t'(i);
            end
        end
        return r;
    endfunction

    function automatic evt_mask_t onehot_of(evt_idx_t idx);
        return evt_mask_t'(1) << idx;
    endfunction

endpackage

// File: rtl/ack_counter.sv
module ack_counter #(
    parameter int ACK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_i,
    output logic retire_o
);
    localparam int CNT_W = (ACK_DIV > 1) ? $clog2(ACK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign retire_o = ack_i && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ack_i) begin
            if (cnt_q == CNT_LAST) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the count restarts after the retiring write
    assert_cnt_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        retire_o |=> (cnt_q == '0));

    // R5: a write that is not the last one advances the count
    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !retire_o) |=> (cnt_q != '0));

endmodule

// File: rtl/pend_tracker.sv
module pend_tracker
    import evtirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      retire_i,
    input  evt_req_t  req_i,
    output evt_mask_t mask_o,
    output evt_mask_t mask_mid_o,
    output evt_pick_t cleared_o
);
    evt_mask_t mask_q;
    evt_mask_t mask_d;

    always_comb begin
        cleared_o  = pick_lowest_from(mask_q, '0);
        mask_mid_o = mask_q;
        if (retire_i && cleared_o.hit)
            mask_mid_o = mask_q & ~onehot_of(cleared_o.idx);
        // new event applied after the clear (R8)
        mask_d = mask_mid_o;
        if (req_i.valid)
            mask_d = mask_mid_o | onehot_of(req_i.idx);
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    // R2: a raised event is pending on the next cycle
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
        req_i.valid |=> mask_q[$past(req_i.idx)]);

    // R5: non-retiring acknowledges without events leave the mask alone
    assert_ack_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (!retire_i && !req_i.valid) |=> $stable(mask_q));

    // R6: a retire with no event removes exactly one pending bit
    assert_retire_one_R6: assert property (@(posedge clk) disable iff (rst)
        (retire_i && !req_i.valid && (mask_q != '0)) |=>
            ($countones(mask_q) == $countones($past(mask_q)) - 1));

endmodule

// File: rtl/num_select.sv
module num_select
    import evtirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      retire_i,
    input  evt_pick_t cleared_i,
    input  evt_mask_t mask_mid_i,
    input  evt_req_t  req_i,
    output evt_idx_t  num_o
);
    evt_idx_t  num_q;
    evt_idx_t  num_mid;
    evt_idx_t  num_d;
    evt_pick_t next_pick;

    always_comb begin
        next_pick = pick_lowest_from(mask_mid_i, cleared_i.idx);
        num_mid   = num_q;
        if (retire_i && cleared_i.hit && next_pick.hit)
            num_mid = next_pick.idx;
        num_d = num_mid;
        if (req_i.valid && ((num_mid == '0) || (req_i.idx < num_mid)))
            num_d = req_i.idx;
    end

    always_ff @(posedge clk) begin
        if (rst) num_q <= '0;
        else     num_q <= num_d;
    end

    assign num_o = num_q;

    // R4: a smaller event index takes the register when no retire happens
    assert_smaller_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (req_i.valid && !retire_i && (req_i.idx < num_q)) |=> (num_q == $past(req_i.idx)));

    // R4: a larger index does not displace a non-zero number
    assert_larger_loses_R4: assert property (@(posedge clk) disable iff (rst)
        (req_i.valid && !retire_i && (num_q != '0) && (req_i.idx >= num_q)) |=> $stable(num_q));

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evtirq_pkg::*;
#(
    parameter int ACK_DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 evt_valid_i,
    input  logic [EVT_IDX_W-1:0] evt_idx_i,
    input  logic                 ack_wr_i,
    output logic                 irq_o,
    output logic [EVT_IDX_W-1:0] evt_num_o,
    output logic [EVT_COUNT-1:0] pend_mask_o
);
    evt_req_t  req;
    logic      retire;
    evt_mask_t mask_q;
    evt_mask_t mask_mid;
    evt_pick_t cleared;
    logic      irq_q;

    assign req.valid = evt_valid_i;
    assign req.idx   = evt_idx_i;

    ack_counter #(.ACK_DIV(ACK_DIV)) u_ack (
        .clk      (clk),
        .rst      (rst),
        .ack_i    (ack_wr_i),
        .retire_o (retire)
    );

    pend_tracker u_pend (
        .clk        (clk),
        .rst        (rst),
        .retire_i   (retire),
        .req_i      (req),
        .mask_o     (mask_q),
        .mask_mid_o (mask_mid),
        .cleared_o  (cleared)
    );

    num_select u_num (
        .clk        (clk),
        .rst        (rst),
        .retire_i   (retire),
        .cleared_i  (cleared),
        .mask_mid_i (mask_mid),
        .req_i      (req),
        .num_o      (evt_num_o)
    );

    // Request line: set by any arrival, dropped when a retire empties the set
    always_ff @(posedge clk) begin
        if (rst)                                    irq_q <= 1'b0;
        else if (req.valid)                         irq_q <= 1'b1;
        else if (retire && (mask_mid == '0))        irq_q <= 1'b0;
    end

    assign irq_o       = irq_q;
    assign pend_mask_o = mask_q;

    // R3: request line mirrors a non-empty pending set
    assert_irq_tracks_R3: assert property (@(posedge clk) disable iff (rst)
        irq_o == (pend_mask_o != '0));

    // R9: retire on an empty set changes nothing visible
    assert_empty_retire_R9: assert property (@(posedge clk) disable iff (rst)
        (retire && !evt_valid_i && (pend_mask_o == '0)) |=>
            ($stable(evt_num_o) && (pend_mask_o == '0)));

    // R8: an event coincident with a retire is never lost
    assert_coincident_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (retire && evt_valid_i) |=> pend_mask_o[$past(evt_idx_i)]);

endmodule

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_valid = 1'b0;
    logic [2:0] evt_idx = '0;
    logic       ack_wr = 1'b0;
    logic       irq;
    logic [2:0] evt_num;
    logic [7:0] pend_mask;

    always #2.5 clk = ~clk;

    evt_irq_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .evt_valid_i (evt_valid),
        .evt_idx_i   (evt_idx),
        .ack_wr_i    (ack_wr),
        .irq_o       (irq),
        .evt_num_o   (evt_num),
        .pend_mask_o (pend_mask)
    );

    typedef struct {
        logic [7:0] mask;
        logic [2:0] num;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    // reference state
    logic [7:0] m_mask = '0;
    logic [2:0] m_num  = '0;
    int         m_cnt  = 0;

    // driver: one cycle of stimulus plus its expected outcome
    task automatic step(input bit r, input bit ev, input int idx, input bit ack, input string tag);
        exp_t e;
        logic [7:0] mid;
        logic [2:0] num;
        int lo;
        @(negedge clk);
        rst = r; evt_valid = ev; evt_idx = 3'(idx); ack_wr = ack;
        if (r) begin
            m_mask = '0; m_num = '0; m_cnt = 0;
        end else begin
            mid = m_mask; num = m_num;
            if (ack) begin
                if (m_cnt == 3) begin
                    m_cnt = 0;
                    lo = -1;
                    for (int i = 0; i < 8; i++) if (lo < 0 && mid[i]) lo = i;
                    if (lo >= 0) begin
                        mid[lo] = 1'b0;
                        for (int j = 7; j >= lo; j--) if (mid[j]) num = 3'(j);
                    end
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (ev) begin
                mid[idx] = 1'b1;
                if (num == 0 || 3'(idx) < num) num = 3'(idx);
            end
            m_mask = mid; m_num = num;
        end
        e.mask = m_mask; e.num = m_num; e.irq = (m_mask != 0); e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk);
    endtask

    task automatic acks(input int n, input string tag);
        for (int k = 0; k < n; k++) step(0, 0, 0, 1, tag);
    endtask

    // monitor: compares after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (pend_mask !== e.mask || evt_num !== e.num || irq !== e.irq) begin
                n_fail++;
                $display("FAIL %s: mask=%h num=%0d irq=%b expected mask=%h num=%0d irq=%b",
                         e.tag, pend_mask, evt_num, irq, e.mask, e.num, e.irq);
            end
        end
    end

    initial begin
        step(1, 0, 0, 0, "R1 reset");
        step(1, 0, 0, 0, "R1 reset hold");
        step(0, 1, 5, 0, "R2 R3 R4 first event");
        step(0, 1, 3, 0, "R4 smaller event");
        step(0, 1, 7, 0, "R4 larger event ignored");
        acks(3, "R5 partial ack");
        step(0, 0, 0, 1, "R6 R7 fourth ack retires");
        step(0, 1, 0, 0, "R4 event zero");
        step(0, 1, 2, 0, "R4 zero displaced");
        acks(4, "R6 R7 retire zero");
        acks(3, "R5 partial ack");
        step(0, 1, 1, 1, "R8 event with retire");
        acks(4, "R7 retire");
        acks(4, "R7 retire");
        acks(4, "R3 R7 retire last keeps number");
        acks(4, "R9 retire on empty");
        step(0, 1, 7, 0, "R3 R4 equal index");
        acks(2, "R5 partial ack");
        step(1, 0, 0, 0, "R1 reset mid count");
        step(0, 1, 4, 0, "R2 after reset");
        acks(3, "R1 R5 count restarted");
        step(0, 0, 0, 1, "R6 retire after reset");
        step(0, 1, 6, 0, "R2 event");
        step(0, 0, 0, 0, "R5 idle");
        @(negedge clk);
        ack_wr = 1'b0; evt_valid = 1'b0;
        @(posedge clk); #2;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule